// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns the system clock into time quanta through a programmable prescaler and walks each nominal bit through four back-to-back segments: a one-quantum synchronization segment, then propagation, then phase 1, then phase 2. It emits a one-cycle strobe where the receive line is to be sampled and another where the next bit starts. A protocol engine uses these strobes to sample the received bit and to launch the next transmitted one.

The receive line is observed once per quantum. A recessive-to-dominant transition while the bus is idle restarts the bit timing (hard synchronization). During traffic, the same transition lengthens phase 1 when it arrives late and shortens phase 2 when it arrives early. Each correction is limited by the programmed jump width. A configuration whose bit is shorter than 8 or longer than 25 quanta is rejected, and the generator stays in its reset state while that configuration is applied.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts 2*(presc+1) clock cycles. `tq_tick` is high for the single cycle that ends each quantum and is never high in two consecutive cycles.
- R2: Segment codes are SYNC=0, PROP=1, PH1=2, PH2=3. They follow that order with wraparound. SYNC lasts 1 quantum, and PROP, PH1 and PH2 last their field value plus 1 quanta, unless R8 or R9 adjusts them. `seg` changes only on a quantum boundary.
- R3: The total 4+prop_len+ph1_len+ph2_len must lie between 8 and 25 for `cfg_ok` to be high. While it is low, there are no ticks, `seg` stays at SYNC and no strobe fires.
- R4: `sample_pt` pulses together with the tick that ends the last quantum of PH1.
- R5: `tx_pt` pulses together with the tick that ends the last quantum of PH2. The next quantum is SYNC.
- R6: `rx` is sampled at every tick, with 1 meaning recessive. An edge is a sample of 0 when the previous tick's sample was 1. The previous sample resets to 1.
- R7: An edge while `bus_idle` is high makes the next quantum the first PROP quantum. It clears any pending adjustment, and no strobe fires on that tick.
- R8: Without `bus_idle`, an edge in PROP or PH1 at quantum position e after SYNC (first PROP quantum is e=1) extends PH1 by min(e, sjw+1) quanta.
- R9: Without `bus_idle`, an edge in PH2 quantum k (0-based) shortens PH2 by min(plen2-k, sjw+1), where plen2=ph2_len+1. If the shortened length is at most k+1, the bit ends on that tick.
- R10: Only the first edge after SYNC in a bit adjusts timing. An edge in SYNC makes no adjustment.
- R11: During reset, `tq_tick`, `sample_pt` and `tx_pt` are low and `seg` is SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 6 | Prescaler; quantum = 2*(presc+1) clocks |
| prop_len | input | 3 | Propagation segment length minus 1 |
| ph1_len | input | 3 | Phase 1 length minus 1 |
| ph2_len | input | 3 | Phase 2 length minus 1 |
| sjw | input | 2 | Jump width minus 1 |
| rx | input | 1 | Synchronized receive line, 1 = recessive |
| bus_idle | input | 1 | High when the bus is idle (hard sync enabled) |
| tq_tick | output | 1 | End-of-quantum pulse |
| seg | output | 2 | Current segment code |
| sample_pt | output | 1 | Sample-point strobe |
| tx_pt | output | 1 | Bit-start (transmit-point) strobe |
| cfg_ok | output | 1 | Configuration within 8..25 quanta |

## Verification
The assertions check the local rules on every cycle: ticks are isolated, segments advance one step at a time, strobes lead into the right segment, adjustments stay within the jump width, a hard sync lands in PROP, and a rejected configuration produces no ticks. Other properties depend on edge timing across a whole bit and show only in the bench scenarios against the reference model. These are the exact amount of lengthening or shortening, the once-per-bit limit, the placement of the sample point after a resynchronization, and the 8/25 boundaries of the configuration.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/cbt_cfg_chk.sv
module cbt_cfg_chk #(
    parameter int SEG_W  = 3,
    parameter int MIN_TQ = 8,
    parameter int MAX_TQ = 25
) (
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    output logic             cfg_ok
);
    localparam int SUM_W = SEG_W + 3;

    logic [SUM_W-1:0] total;

    // sync (1) + three programmable segments, each field + 1
    always_comb begin
        total  = SUM_W'(4) + SUM_W'(prop_len) + SUM_W'(ph1_len) + SUM_W'(ph2_len);
        cfg_ok = (int'(total) >= MIN_TQ) && (int'(total) <= MAX_TQ);
    end
endmodule

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               tq_tick
);
    localparam int CNT_W = PRESC_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_s;

    div_s             s_d, s_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim     = {presc, 1'b1};           // 2*(presc+1)-1
        tq_tick = en && (s_q.cnt >= lim);
        s_d     = s_q;
        if (!en)          s_d.cnt = '0;
        else if (tq_tick) s_d.cnt = '0;
        else              s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> !tq_tick); // R1
endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
    import can_bt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tq_tick,
    input  logic             rx,
    input  logic             bus_idle,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw,
    output seg_e             seg_o,
    output logic             sample_pt,
    output logic             tx_pt
);
    localparam int CNT_W = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 2;
    localparam int ADJ_W = SJW_W + 1;

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [ADJ_W-1:0] ext;
        logic [ADJ_W-1:0] shr;
        logic             synced;
        logic             prev_rx;
    } seq_s;

    localparam seq_s SEQ_RST = '{seg: SEG_SYNC, cnt: '0, ext: '0, shr: '0,
                                 synced: 1'b0, prev_rx: 1'b1};

    seq_s             s_d, s_q;
    logic [CNT_W-1:0] p_len, a_len, b_len, jw, err, seg_len;
    logic [ADJ_W-1:0] ext_n, shr_n;
    logic             syn_n, fall, hard, last;

    function automatic logic [CNT_W-1:0] min_q(input logic [CNT_W-1:0] x,
                                               input logic [CNT_W-1:0] y);
        return (x < y) ? x : y;
    endfunction

    always_comb begin
        p_len     = CNT_W'(prop_len) + 1'b1;
        a_len     = CNT_W'(ph1_len) + 1'b1;
        b_len     = CNT_W'(ph2_len) + 1'b1;
        jw        = CNT_W'(sjw) + 1'b1;
        fall      = tq_tick && s_q.prev_rx && !rx;
        hard      = 1'b0;
        sample_pt = 1'b0;
        tx_pt     = 1'b0;
        err       = '0;
        seg_len   = '0;
        last      = 1'b0;
        ext_n     = s_q.ext;
        shr_n     = s_q.shr;
        syn_n     = s_q.synced;
        s_d       = s_q;
        if (!en) begin
            s_d = SEQ_RST;
        end else if (tq_tick) begin
            s_d.prev_rx = rx;
            if (fall && bus_idle) begin
                hard       = 1'b1;
                s_d.seg    = SEG_PROP;
                s_d.cnt    = '0;
                s_d.ext    = '0;
                s_d.shr    = '0;
                s_d.synced = 1'b1;
            end else begin
                if (fall && !s_q.synced && s_q.seg != SEG_SYNC) begin
                    syn_n = 1'b1;
                    case (s_q.seg)
                        SEG_PROP: begin
                            err   = s_q.cnt + 1'b1;
                            ext_n = ADJ_W'(min_q(err, jw));
                        end
                        SEG_PH1: begin
                            err   = p_len + s_q.cnt + 1'b1;
                            ext_n = ADJ_W'(min_q(err, jw));
                        end
                        default: begin
                            err   = b_len - s_q.cnt;
                            shr_n = ADJ_W'(min_q(err, jw));
                        end
                    endcase
                end
                case (s_q.seg)
                    SEG_SYNC: seg_len = CNT_W'(1);
                    SEG_PROP: seg_len = p_len;
                    SEG_PH1:  seg_len = a_len + CNT_W'(ext_n);
                    default:  seg_len = b_len - CNT_W'(shr_n);
                endcase
                last = (s_q.cnt + 1'b1) >= seg_len;
                if (last) begin
                    s_d.cnt = '0;
                    case (s_q.seg)
                        SEG_SYNC: s_d.seg = SEG_PROP;
                        SEG_PROP: s_d.seg = SEG_PH1;
                        SEG_PH1: begin
                            s_d.seg   = SEG_PH2;
                            sample_pt = 1'b1;
                        end
                        default: begin
                            s_d.seg = SEG_SYNC;
                            tx_pt   = 1'b1;
                            ext_n   = '0;
                            shr_n   = '0;
                            syn_n   = 1'b0;
                        end
                    endcase
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
                s_d.ext    = ext_n;
                s_d.shr    = shr_n;
                s_d.synced = syn_n;
            end
        end
        seg_o = s_q.seg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    AST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tq_tick && !hard) |=> (s_q.seg == $past(s_q.seg) ||
            2'(s_q.seg) == 2'($past(s_q.seg)) + 2'd1)); // R2
    AST_SEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tq_tick) |=> $stable(s_q.seg)); // R2
    AST_SAMPLE_TO_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |=> (s_q.seg == SEG_PH2)); // R4
    AST_TX_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pt |=> (s_q.seg == SEG_SYNC && s_q.ext == '0 && s_q.shr == '0)); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pt && tx_pt)); // R4
    AST_HARD_TO_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (s_q.seg == SEG_PROP && s_q.cnt == '0)); // R7
    AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(s_q.ext) <= jw); // R8
    AST_SHR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(s_q.shr) <= jw); // R9
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int PRESC_W = 6,
    parameter int SEG_W   = 3,
    parameter int SJW_W   = 2,
    parameter int MIN_TQ  = 8,
    parameter int MAX_TQ  = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic [SEG_W-1:0]   prop_len,
    input  logic [SEG_W-1:0]   ph1_len,
    input  logic [SEG_W-1:0]   ph2_len,
    input  logic [SJW_W-1:0]   sjw,
    input  logic               rx,
    input  logic               bus_idle,
    output logic               tq_tick,
    output logic [1:0]         seg,
    output logic               sample_pt,
    output logic               tx_pt,
    output logic               cfg_ok
);
    can_bt_pkg::seg_e seg_w;

    cbt_cfg_chk #(.SEG_W(SEG_W), .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)) u_cfg (
        .prop_len (prop_len),
        .ph1_len  (ph1_len),
        .ph2_len  (ph2_len),
        .cfg_ok   (cfg_ok)
    );

    cbt_tq_div #(.PRESC_W(PRESC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_ok),
        .presc   (presc),
        .tq_tick (tq_tick)
    );

    cbt_seg_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_ok),
        .tq_tick   (tq_tick),
        .rx        (rx),
        .bus_idle  (bus_idle),
        .prop_len  (prop_len),
        .ph1_len   (ph1_len),
        .ph2_len   (ph2_len),
        .sjw       (sjw),
        .seg_o     (seg_w),
        .sample_pt (sample_pt),
        .tx_pt     (tx_pt)
    );

    assign seg = 2'(seg_w);

    AST_HOLD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (!tq_tick && !sample_pt && !tx_pt)); // R3
endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
    localparam int PW = 6;
    localparam int SW = 3;
    localparam int JW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] presc = '0;
    logic [SW-1:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
    logic [JW-1:0] sjw = '0;
    logic          rx = 1'b1;
    logic          bus_idle = 1'b0;
    logic          tq_tick, sample_pt, tx_pt, cfg_ok;
    logic [1:0]    seg;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .presc(presc), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw(sjw), .rx(rx),
        .bus_idle(bus_idle), .tq_tick(tq_tick), .seg(seg),
        .sample_pt(sample_pt), .tx_pt(tx_pt), .cfg_ok(cfg_ok)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string scen = "R11";
    bit    done = 1'b0;

    // behavioural reference: position of the current quantum inside the bit
    int m_div = 0, m_pos = 0, m_ext = 0, m_shr = 0;
    bit m_syn = 1'b0, m_prev = 1'b1;
    int pl, al, bl, jl, lim, sg, blen, k;
    bit valid, e_tick, e_samp, e_tx, fall;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual %0d expected %0d at %0t", tag, scen, act, exp, $time);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_reset();
        m_div = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_syn = 1'b0; m_prev = 1'b1;
    endtask

    always begin
        @(negedge clk);
        #4;
        if (!rst_n) begin
            model_reset();
        end else begin
            pl = int'(prop_len) + 1; al = int'(ph1_len) + 1; bl = int'(ph2_len) + 1;
            jl = int'(sjw) + 1; lim = 2 * int'(presc) + 1;
            valid  = (pl + al + bl + 1 >= 8) && (pl + al + bl + 1 <= 25);
            sg     = (m_pos == 0) ? 0 : (m_pos <= pl) ? 1 : (m_pos <= pl + al + m_ext) ? 2 : 3;
            e_tick = valid && (m_div >= lim);
            e_samp = 1'b0;
            e_tx   = 1'b0;
            chk("R1 tq_tick", int'(tq_tick), int'(e_tick));
            chk("R2 seg", int'(seg), sg);
            chk("R3 cfg_ok", int'(cfg_ok), int'(valid));
            if (!valid) begin
                model_reset();
            end else if (e_tick) begin
                m_div = 0;
                fall  = m_prev && !rx;           // R6
                m_prev = rx;
                if (fall && bus_idle) begin      // R7
                    m_pos = 1; m_ext = 0; m_shr = 0; m_syn = 1'b1;
                end else begin
                    if (fall && !m_syn && sg != 0) begin  // R10
                        m_syn = 1'b1;
                        if (sg <= 2) m_ext = imin(m_pos, jl);          // R8
                        else begin                                     // R9
                            k = m_pos - (1 + pl + al + m_ext);
                            m_shr = imin(bl - k, jl);
                        end
                    end
                    blen = 1 + pl + al + m_ext + bl - m_shr;
                    if (sg == 2 && m_pos == pl + al + m_ext) e_samp = 1'b1;
                    if (m_pos + 1 >= blen) begin
                        e_tx = 1'b1; m_pos = 0; m_ext = 0; m_shr = 0; m_syn = 1'b0;
                    end else begin
                        m_pos++;
                    end
                end
            end else begin
                m_div++;
            end
            chk("R4 sample_pt", int'(sample_pt), int'(e_samp));
            chk("R5 tx_pt", int'(tx_pt), int'(e_tx));
        end
    end

    task automatic apply(input int pr, input int p, input int a, input int b, input int j);
        @(negedge clk);
        rst_n = 1'b0;
        presc = PW'(pr); prop_len = SW'(p); ph1_len = SW'(a); ph2_len = SW'(b); sjw = JW'(j);
        rx = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_rx(input int cycles, input int minw, input int maxw);
        int left = cycles;
        while (left > 0) begin
            int w = int'($urandom_range(maxw, minw));
            repeat (w) @(negedge clk);
            rx = ~rx;
            left -= w;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #4;
        // R11: reset state
        chk("R11 tq_tick", int'(tq_tick), 0);
        chk("R11 seg", int'(seg), 0);
        chk("R11 sample_pt", int'(sample_pt), 0);
        chk("R11 tx_pt", int'(tx_pt), 0);

        scen = "R3 total 4";
        apply(0, 0, 0, 0, 0);
        run_rx(120, 3, 20);
        scen = "R3 total 7";
        apply(0, 1, 1, 1, 0);
        run_rx(120, 3, 20);
        scen = "R3 total 8";
        apply(0, 1, 1, 2, 0);
        repeat (200) @(negedge clk);

        scen = "R1 R2 R4 R5 short bit";
        apply(0, 1, 2, 2, 1);
        repeat (300) @(negedge clk);
        scen = "R1 R2 R4 R5 25-quantum bit";
        apply(2, 7, 7, 7, 3);
        repeat (800) @(negedge clk);

        scen = "R6 R7 hard sync";
        apply(1, 2, 3, 3, 1);
        bus_idle = 1'b1;
        run_rx(2500, 4, 70);
        bus_idle = 1'b0;

        scen = "R8 R9 R10 sjw 1";
        apply(1, 2, 3, 3, 0);
        run_rx(4000, 5, 90);
        scen = "R8 R9 R10 sjw 4";
        apply(1, 2, 4, 4, 3);
        run_rx(4000, 5, 90);
        scen = "R10 multi-edge bits";
        apply(0, 3, 5, 5, 2);
        run_rx(3000, 2, 9);
        scen = "R6 R7 R8 R9 mixed";
        apply(0, 0, 3, 3, 3);
        for (int i = 0; i < 20; i++) begin
            bus_idle = (i % 3 == 0);
            run_rx(150, 3, 40);
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule